// File: doc/BRIEF.md
# Configuration Read Retry Handler

This block sits between a host that issues configuration reads and the downstream configuration access path of a root complex. It forwards one read at a time. An endpoint that is not ready may answer with Configuration Request Retry Status. The block sees this either as a completion status of 2 or as returned data equal to the retry marker 0xFFFF0001. In that case it waits a fixed interval of about one microsecond and sends the same read again. It stops when real data arrives or when the retry budget is used up. If the budget runs out it returns all-ones and raises a timeout flag alongside the response.

Two cases do not retry. Reads aimed at bus 0, which is the root port itself, go through once and their completion data is returned as it arrives. When software visibility is enabled, a retry indication on a read of dword offset 0 (the Vendor ID dword) is not retried: the block hands the marker value back so that software can see the retry. Narrow reads of one or two bytes return only the addressed lane of the 32-bit word.

Top module: `cfg_rd_retry`

## Requirements
- R1: `req_ready` is high only when no read is in progress. Once a request is accepted, no new request is taken until its single-cycle response on `rsp_valid` has been given, and `rsp_valid` stays low in the cycle after it.
- R2: When `req_bus` is 0, the read is issued downstream exactly once. `cpl_data` is returned whatever the completion status, with no substitution, and `rsp_timeout` stays low.
- R3: On a nonzero bus, a completion with status 2, or with status 0 and data 0xFFFF0001, is a retry indication unless R4 applies. The same read is then reissued. The reissue is offered on `dn_valid` exactly `TICK_DIV`+1 clock cycles after the cycle in which the completion was presented.
- R4: When `sv_enable` is 1 and the read targets dword offset 0 (`req_addr[11:2]` equal to 0), a retry indication is not reissued. The word 0xFFFF0001 is returned and `rsp_timeout` stays low.
- R5: If the completion to the read issued after `TIMEOUT_TICKS` reissues is still a retry indication, the word 0xFFFFFFFF is returned with `rsp_timeout` high. The read is issued `TIMEOUT_TICKS`+1 times in total. If real data arrives on the last allowed reissue, that data is returned and the timeout flag stays low.
- R6: On a nonzero bus, a status-0 completion with data other than the marker returns that data. Any status other than 0 or 2 returns 0xFFFFFFFF without a retry.
- R7: `req_size` encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. For 1- and 2-byte reads, `rsp_data` is the returned word shifted right by 8 × `req_addr[1:0]` and masked to 8 or 16 bits. For 4-byte reads the whole word is returned.
- R8: While `rst_n` is low at a clock edge, the block returns to idle with `req_ready` high, `dn_valid` and `rsp_valid` low, and the retry count cleared.
- R9: Each downstream read carries the requested bus and device/function, and `dn_addr` equals `req_addr` with bits 1:0 cleared. `dn_valid` and `dn_addr` hold steady until `dn_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sv_enable | input | 1 | Retry-status software visibility enable |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Target device and function |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 2 | Access size code |
| dn_valid | output | 1 | Downstream read valid |
| dn_ready | input | 1 | Downstream path accepts the read |
| dn_bus | output | BUS_W | Downstream bus number |
| dn_devfn | output | DEVFN_W | Downstream device and function |
| dn_addr | output | ADDR_W | Dword-aligned downstream address |
| cpl_valid | input | 1 | Downstream completion valid |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion data word |
| rsp_valid | output | 1 | Final response pulse |
| rsp_data | output | 32 | Response data, lane-extracted |
| rsp_timeout | output | 1 | Response produced by timeout substitution |

## Verification
The assertions assume that the downstream side presents a completion only while a read is awaiting one, one completion per issued read, and that `sv_enable` stays constant during a transaction. The bench's downstream model only answers after it has seen a read accepted. It presents each completion for exactly one cycle, and it changes `sv_enable` only between transactions, while the block is idle. Random requests draw a mix of buses, offsets, sizes, retry counts on both sides of the budget, and both forms of retry indication. Directed cases cover the exact budget edge, lanes at the top of the word, and the visibility rule.

// File: rtl/cfg_rd_retry.sv
module cfg_rd_retry #(
  parameter int TICK_DIV      = 200,
  parameter int TIMEOUT_TICKS = 500000,
  parameter int CNT_W         = 19,
  parameter int BUS_W         = 8,
  parameter int DEVFN_W       = 8,
  parameter int ADDR_W        = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sv_enable,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [BUS_W-1:0]   dn_bus,
  output logic [DEVFN_W-1:0] dn_devfn,
  output logic [ADDR_W-1:0]  dn_addr,
  input  logic               cpl_valid,
  input  logic [2:0]         cpl_status,
  input  logic [31:0]        cpl_data,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic               rsp_timeout
);

  localparam int          PRE_W   = $clog2(TICK_DIV + 1);
  localparam logic [31:0] MARKER  = 32'hFFFF_0001;
  localparam logic [2:0]  ST_OK   = 3'd0;
  localparam logic [2:0]  ST_RTY  = 3'd2;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TIMEOUT_TICKS);
  localparam logic [PRE_W-1:0] PRE_LD  = PRE_W'(TICK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE, S_RESP} st_t;

  st_t                st;
  logic [BUS_W-1:0]   bus_q;
  logic [DEVFN_W-1:0] devfn_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         size_q;
  logic [CNT_W-1:0]   rcnt;
  logic [PRE_W-1:0]   pre;
  logic [31:0]        word_q;
  logic               tmo_q;

  logic        bypass, off0, marker_in, sv_hit, retry, expire;
  logic [31:0] word_n, shifted;

  assign bypass    = (bus_q == '0);
  assign off0      = (addr_q[ADDR_W-1:2] == '0);
  assign marker_in = (cpl_status == ST_RTY) || (cpl_status == ST_OK && cpl_data == MARKER);
  assign sv_hit    = sv_enable && off0;
  assign retry     = !bypass && marker_in && !sv_hit;
  assign expire    = retry && (rcnt == CNT_LIM);

  always_comb begin
    if (bypass)              word_n = cpl_data;
    else if (marker_in)      word_n = sv_hit ? MARKER : 32'hFFFF_FFFF;
    else if (cpl_status == ST_OK) word_n = cpl_data;
    else                     word_n = 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bus_q   <= '0;
      devfn_q <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      rcnt    <= '0;
      pre     <= '0;
      word_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          bus_q   <= req_bus;
          devfn_q <= req_devfn;
          addr_q  <= req_addr;
          size_q  <= req_size;
          rcnt    <= '0;
          tmo_q   <= 1'b0;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (dn_ready) st <= S_WAIT;
        S_WAIT: if (cpl_valid) begin
          if (retry && !expire) begin
            rcnt <= rcnt + 1'b1;
            pre  <= PRE_LD;
            st   <= S_PAUSE;
          end else begin
            word_q <= word_n;
            tmo_q  <= expire;
            st     <= S_RESP;
          end
        end
        S_PAUSE: begin
          if (pre == '0) st <= S_ISSUE;
          else           pre <= pre - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign dn_valid    = (st == S_ISSUE);
  assign dn_bus      = bus_q;
  assign dn_devfn    = devfn_q;
  assign dn_addr     = {addr_q[ADDR_W-1:2], 2'b00};
  assign rsp_valid   = (st == S_RESP);
  assign rsp_timeout = rsp_valid && tmo_q;

  assign shifted = word_q >> {addr_q[1:0], 3'b000};
  always_comb begin
    case (size_q)
      2'd0:    rsp_data = {24'h0, shifted[7:0]};
      2'd1:    rsp_data = {16'h0, shifted[15:0]};
      default: rsp_data = word_q;
    endcase
  end

  AST_NO_NEW_REQ:   assert property (@(posedge clk) disable iff (!rst_n)
                      (req_valid && req_ready) |=> !req_ready); // R1
  AST_RSP_PULSE:    assert property (@(posedge clk) disable iff (!rst_n)
                      rsp_valid |=> (!rsp_valid && req_ready)); // R1
  AST_BYPASS_NOTMO: assert property (@(posedge clk) disable iff (!rst_n)
                      rsp_timeout |-> (dn_bus != '0)); // R2
  AST_SV_NO_RETRY:  assert property (@(posedge clk) disable iff (!rst_n)
                      (st == S_WAIT && cpl_valid && sv_enable && dn_addr[ADDR_W-1:2] == '0)
                      |=> (rsp_valid && !rsp_timeout)); // R4
  AST_CNT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n)
                      rcnt <= CNT_LIM); // R5
  AST_TMO_ONES:     assert property (@(posedge clk) disable iff (!rst_n)
                      (rsp_timeout && size_q[1]) |-> (rsp_data == 32'hFFFF_FFFF)); // R5
  AST_DN_HOLD:      assert property (@(posedge clk) disable iff (!rst_n)
                      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr))); // R9

endmodule

// File: tb/tb_cfg_rd_retry.sv
module tb_cfg_rd_retry;
  localparam int TD  = 4;
  localparam int TMO = 5;

  logic clk = 0, rst_n = 0, sv_enable = 0;
  logic req_valid = 0, dn_ready = 1, cpl_valid = 0;
  logic [7:0] req_bus = 0, req_devfn = 0;
  logic [11:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [2:0] cpl_status = 0;
  logic [31:0] cpl_data = 0;
  logic req_ready, dn_valid, rsp_valid, rsp_timeout;
  logic [7:0] dn_bus, dn_devfn;
  logic [11:0] dn_addr;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0, cyc = 0;
  int n_crs = 0, kind = 0, reads = 0, last_cpl = 0;
  logic [2:0] fstat = 0;
  logic [31:0] fdata = 0, cdata = 0;
  logic [7:0] e_bus = 0, e_devfn = 0;
  logic [11:0] e_addr = 0;

  cfg_rd_retry #(.TICK_DIV(TD), .TIMEOUT_TICKS(TMO)) dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input logic [31:0] w, input logic [11:0] a, input logic [1:0] s);
    logic [31:0] t = w >> (8 * a[1:0]);
    if (s == 2'd0) return t & 32'hFF;
    if (s == 2'd1) return t & 32'hFFFF;
    return w;
  endfunction

  initial begin : responder
    forever begin
      @(negedge clk);
      if (dn_valid) begin
        chk(dn_addr == {e_addr[11:2], 2'b00} && dn_bus == e_bus && dn_devfn == e_devfn,
            "R9 addr", {8'h0, dn_bus, dn_addr}, {8'h0, e_bus, e_addr[11:2], 2'b00});
        if (reads > 0) chk(cyc - last_cpl == TD + 1, "R3 gap", cyc - last_cpl, TD + 1);
        reads++;
        @(negedge clk);
        if (reads <= n_crs) begin
          cpl_status = (kind == 0) ? 3'd2 : 3'd0;
          cpl_data   = (kind == 0) ? cdata : 32'hFFFF0001;
        end else begin
          cpl_status = fstat;
          cpl_data   = fdata;
        end
        cpl_valid = 1;
        last_cpl = cyc;
        @(negedge clk);
        cpl_valid = 0;
      end
    end
  end

  task automatic do_read(input logic [7:0] bus, input logic [11:0] addr, input logic [1:0] size,
                         input bit sv, input int ncrs, input int knd,
                         input logic [2:0] fs, input logic [31:0] fd);
    logic [31:0] w;
    int er, guard;
    bit et;
    if (bus == 0) begin
      w = (ncrs > 0) ? ((knd == 0) ? cdata : 32'hFFFF0001) : fd; er = 1; et = 0;
    end else if (ncrs > 0 && sv && addr[11:2] == 0) begin
      w = 32'hFFFF0001; er = 1; et = 0;
    end else if (ncrs > TMO) begin
      w = 32'hFFFFFFFF; er = TMO + 1; et = 1;
    end else begin
      w = (fs == 0) ? fd : 32'hFFFFFFFF; er = ncrs + 1; et = 0;
    end
    @(negedge clk);
    n_crs = ncrs; kind = knd; fstat = fs; fdata = fd; reads = 0;
    e_bus = bus; e_devfn = bus ^ 8'h5A; e_addr = addr; sv_enable = sv;
    chk(req_ready == 1, "R1 idle ready", {31'h0, req_ready}, 1);
    req_valid = 1; req_bus = bus; req_devfn = bus ^ 8'h5A; req_addr = addr; req_size = size;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R1 busy", {31'h0, req_ready}, 0);
    guard = 0;
    while (!rsp_valid && guard < 5000) begin @(negedge clk); guard++; end
    chk(rsp_data == lane(w, addr, size), (size == 2) ? "R6 data" : "R7 lane", rsp_data, lane(w, addr, size));
    chk(rsp_timeout == et, et ? "R5 flag" : "R2 R4 flag", {31'h0, rsp_timeout}, {31'h0, et});
    chk(reads == er, "R3 R5 reads", reads, er);
    @(negedge clk);
    chk(rsp_valid == 0, "R1 pulse", {31'h0, rsp_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && dn_valid == 0 && rsp_valid == 0, "R8 reset",
        {29'h0, req_ready, dn_valid, rsp_valid}, 32'h4);
    rst_n = 1;
    cdata = 32'h1234ABCD;
    do_read(8'd0, 12'h000, 2'd2, 0, 2, 0, 0, 32'h0);           // R2 bus 0 returns CRS data raw
    do_read(8'd3, 12'h000, 2'd2, 1, 2, 0, 0, 32'h11112222);     // R4 status form
    do_read(8'd3, 12'h002, 2'd1, 1, 1, 1, 0, 32'h11112222);     // R4 marker form, R7 lane
    do_read(8'd4, 12'h004, 2'd2, 1, 3, 0, 0, 32'hCAFEF00D);     // R3 non-zero offset retried
    do_read(8'd4, 12'h010, 2'd2, 0, TMO, 1, 0, 32'hA5A5A5A5);   // R5 budget edge success
    do_read(8'd4, 12'h010, 2'd2, 0, TMO + 1, 0, 0, 32'h0);      // R5 timeout
    do_read(8'd4, 12'h010, 2'd0, 0, TMO + 2, 1, 0, 32'h0);      // R5 R7 timeout byte
    do_read(8'd9, 12'h020, 2'd2, 0, 0, 0, 3'd1, 32'h12345678);  // R6 other status
    do_read(8'd9, 12'h023, 2'd0, 0, 0, 0, 0, 32'h89ABCDEF);     // R7 top byte
    do_read(8'd9, 12'h023, 2'd1, 0, 0, 0, 0, 32'h89ABCDEF);     // R7 halfword at 3
    for (int i = 0; i < 50; i++) begin
      logic [7:0] b;
      logic [11:0] a;
      logic [31:0] d;
      logic [2:0] s;
      b = ($urandom % 4 == 0) ? 8'd0 : 8'(1 + $urandom % 200);
      a = ($urandom % 3 == 0) ? 12'($urandom % 4) : 12'($urandom);
      d = $urandom;
      if (d == 32'hFFFF0001) d = 32'h0;
      s = ($urandom % 5 == 0) ? 3'd4 : 3'd0;
      cdata = $urandom;
      do_read(b, a, 2'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 2), s, d);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule